// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block gives a host access to a network card's local packet memory through one data port instead of a memory-mapped window. The host loads a 16-bit pointer and a 16-bit length through a small byte-wide register file. Every strobe on the data port then moves one byte or one little-endian 16-bit word at the pointer. After each move the pointer steps forward and the length counts down. When the pointer reaches the end of the receive ring, it folds back to the ring's first page. When the length runs out, a completion flag is raised.

The same register file holds the ring bounds, the access-width selector, an eight-bit flag register with write-one-to-clear semantics, an enable mask and a level interrupt output. Six event inputs let neighbouring logic raise the low flag bits. Local memory has two live windows: a small identity area at address zero, and the packet buffer. Reads that fall outside both windows return all ones, and writes that fall outside them are lost.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset the flag register (offset 0x7) reads 0x80, and the mask (0x8), pointer (0x3 low, 0x4 high), length (0x5 low, 0x6 high), ring pages (0x1 first, 0x2 end) and width (0x9) all read 0. The interrupt is low.
- R2: Writing the low or high byte of the pointer or the length replaces only that byte and keeps the other one. A register read returns the current value combinationally.
- R3: With width bit 0 clear, each data-port strobe writes wdata[7:0] to the pointer address, or returns {8'h00, byte}. The pointer then rises by 1 and the length falls by 1.
- R4: With width bit 0 set, each strobe moves two bytes at the pointer with bit 0 forced low: the lower address carries bits 7..0 and the next address carries bits 15..8. The stored pointer then rises by 2.
- R5: After a step, a pointer equal to the end page times 256 is reloaded with the first page times 256.
- R6: If the length is less than or equal to the step size, it becomes 0 and flag bit 6 (0x40) is set. Otherwise the step size is subtracted. Data-port reads proceed even when the length is 0.
- R7: A data-port write while the length is 0 changes neither memory nor the pointer.
- R8: Only addresses below PROM_BYTES and the range [PMEM_BASE, PMEM_BASE+PMEM_BYTES) hold data. Outside these windows writes are dropped, byte reads return 0x00FF and word reads return 0xFFFF.
- R9: A command write (offset 0x0) with bit 0 (remote read) or bit 1 (remote write) set while the length is 0 sets flag bit 6 on the next edge.
- R10: irq is high exactly when (flags AND mask AND 0x7F) is nonzero. Flag bit 7 never raises it.
- R11: A flag write clears every bit among 6..0 where the written value is 1 and leaves bit 7 alone. Any command write clears bit 7.
- R12: A pulse on ev_set[k] sets flag bit k, for k from 0 to 5.
- R13: Data-port read data is valid in the same cycle as the strobe. The pointer and length change on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dp_rd | input | 1 | Data-port read strobe |
| dp_wr | input | 1 | Data-port write strobe |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data-port read data (combinational) |
| ev_set | input | 6 | Event pulses that set flag bits 5..0 |
| irq | output | 1 | Level interrupt |

## Verification
Byte and word streams are written and then read back with a known address pattern. A word read from an odd pointer shows whether bit 0 is forced low while the stored pointer stays odd. Streams that cross the ring end in each width tell the wrap-to-first-page rule apart from a plain 16-bit rollover. Lengths of 3 with a step of 2 separate the saturate-to-zero rule from subtraction. Accesses at the edge of each memory window, zero-length writes and zero-length commands show that dropped writes, all-ones reads and the immediate completion flag are each handled on their own path.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  localparam int RD_AW = 16;
  localparam int RD_DW = 16;
  localparam int RD_BW = 8;
  localparam int RD_LANES = RD_DW / RD_BW;

  typedef logic [RD_AW-1:0] rd_addr_t;
  typedef logic [RD_AW-1:0] rd_cnt_t;
  typedef logic [RD_BW-1:0] rd_byte_t;

  typedef enum logic [3:0] {
    REG_CMD     = 4'h0,
    REG_RING_LO = 4'h1,
    REG_RING_HI = 4'h2,
    REG_PTR_L   = 4'h3,
    REG_PTR_H   = 4'h4,
    REG_LEN_L   = 4'h5,
    REG_LEN_H   = 4'h6,
    REG_FLAGS   = 4'h7,
    REG_ENABLE  = 4'h8,
    REG_WIDTH   = 4'h9
  } reg_sel_e;

  localparam int BIT_XFER_DONE = 6;
  localparam int BIT_POWERUP   = 7;
  localparam rd_byte_t IRQ_ELIGIBLE = 8'h7F;

  typedef struct packed {
    rd_cnt_t left;
    logic    done;
  } cnt_step_t;

  // bytes moved by one data-port access
  function automatic rd_addr_t f_step_size(input logic wide);
    return wide ? rd_addr_t'(2) : rd_addr_t'(1);
  endfunction

  // page number to byte address
  function automatic rd_addr_t f_page_addr(input rd_byte_t pg);
    return {pg, 8'h00};
  endfunction

  // advance pointer, fold at the ring end
  function automatic rd_addr_t f_adv_addr(input rd_addr_t a, input rd_addr_t sz,
                                          input rd_addr_t first, input rd_addr_t last_ex);
    rd_addr_t sum;
    sum = a + sz;
    return (sum == last_ex) ? first : sum;
  endfunction

  // count down, saturating at zero and flagging exhaustion
  function automatic cnt_step_t f_dec_cnt(input rd_cnt_t c, input rd_addr_t sz);
    cnt_step_t r;
    if (c <= sz) begin
      r.left = '0;
      r.done = 1'b1;
    end else begin
      r.left = c - sz;
      r.done = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/rdma_regs.sv
module rdma_regs import rdma_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reg_wr,
  input  logic [3:0] reg_addr,
  input  rd_byte_t reg_wdata,
  input  rd_byte_t flags,
  input  rd_byte_t mask,
  input  rd_addr_t cur_addr,
  input  rd_cnt_t  cur_cnt,
  output rd_addr_t first_addr,
  output rd_addr_t end_addr,
  output logic     wide,
  output logic     ld_ptr_l,
  output logic     ld_ptr_h,
  output logic     ld_len_l,
  output logic     ld_len_h,
  output logic     cmd_wr,
  output logic     xfer_req,
  output logic     flags_wr,
  output logic     mask_wr,
  output rd_byte_t reg_rdata
);

  reg_sel_e sel;
  rd_byte_t ring_first_pg;
  rd_byte_t ring_end_pg;
  logic     width_q;

  assign sel = reg_sel_e'(reg_addr);

  // write strobes
  assign cmd_wr   = reg_wr && (sel == REG_CMD);
  assign ld_ptr_l = reg_wr && (sel == REG_PTR_L);
  assign ld_ptr_h = reg_wr && (sel == REG_PTR_H);
  assign ld_len_l = reg_wr && (sel == REG_LEN_L);
  assign ld_len_h = reg_wr && (sel == REG_LEN_H);
  assign flags_wr = reg_wr && (sel == REG_FLAGS);
  assign mask_wr  = reg_wr && (sel == REG_ENABLE);
  assign xfer_req = reg_wdata[0] | reg_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_first_pg <= '0;
      ring_end_pg   <= '0;
      width_q       <= 1'b0;
    end else if (reg_wr) begin
      case (sel)
        REG_RING_LO: ring_first_pg <= reg_wdata;
        REG_RING_HI: ring_end_pg   <= reg_wdata;
        REG_WIDTH:   width_q       <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  assign first_addr = f_page_addr(ring_first_pg);
  assign end_addr   = f_page_addr(ring_end_pg);
  assign wide       = width_q;

  always_comb begin
    case (sel)
      REG_RING_LO: reg_rdata = ring_first_pg;
      REG_RING_HI: reg_rdata = ring_end_pg;
      REG_PTR_L:   reg_rdata = cur_addr[RD_BW-1:0];
      REG_PTR_H:   reg_rdata = cur_addr[RD_AW-1:RD_BW];
      REG_LEN_L:   reg_rdata = cur_cnt[RD_BW-1:0];
      REG_LEN_H:   reg_rdata = cur_cnt[RD_AW-1:RD_BW];
      REG_FLAGS:   reg_rdata = flags;
      REG_ENABLE:  reg_rdata = mask;
      REG_WIDTH:   reg_rdata = {7'b0, width_q};
      default:     reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rdma_xfer.sv
module rdma_xfer import rdma_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ld_ptr_l,
  input  logic     ld_ptr_h,
  input  logic     ld_len_l,
  input  logic     ld_len_h,
  input  rd_byte_t ld_data,
  input  logic     step,
  input  logic     wide,
  input  rd_addr_t first_addr,
  input  rd_addr_t end_addr,
  output rd_addr_t cur_addr,
  output rd_cnt_t  cur_cnt,
  output logic     cnt_zero,
  output logic     xfer_done
);

  rd_addr_t  size;
  rd_addr_t  adv;
  cnt_step_t dec;
  logic      any_ld;

  assign size      = f_step_size(wide);
  assign adv       = f_adv_addr(cur_addr, size, first_addr, end_addr);
  assign dec       = f_dec_cnt(cur_cnt, size);
  assign cnt_zero  = (cur_cnt == '0);
  assign xfer_done = step & dec.done;
  assign any_ld    = ld_ptr_l | ld_ptr_h | ld_len_l | ld_len_h;

  // pointer: register loads take priority over a step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cur_addr <= '0;
    else if (ld_ptr_l) cur_addr[RD_BW-1:0] <= ld_data;
    else if (ld_ptr_h) cur_addr[RD_AW-1:RD_BW] <= ld_data;
    else if (step)     cur_addr <= adv;
  end

  // remaining length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cur_cnt <= '0;
    else if (ld_len_l) cur_cnt[RD_BW-1:0] <= ld_data;
    else if (ld_len_h) cur_cnt[RD_AW-1:RD_BW] <= ld_data;
    else if (step)     cur_cnt <= dec.left;
  end

  AST_LEN_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !any_ld && cur_cnt > size) |=> cur_cnt == $past(cur_cnt - size)); // R6
  AST_LEN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !any_ld) |=> cur_cnt == '0); // R6
  AST_PTR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !any_ld && (cur_addr + size) == end_addr) |=> cur_addr == $past(first_addr)); // R5
  AST_PTR_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ptr_h && !ld_ptr_l) |=> cur_addr[RD_BW-1:0] == $past(cur_addr[RD_BW-1:0])); // R2

endmodule

// File: rtl/rdma_mem.sv
module rdma_mem import rdma_pkg::*; #(
  parameter int PROM_BYTES = 32,
  parameter int PMEM_BASE  = 1024,
  parameter int PMEM_BYTES = 1024
) (
  input  logic             clk,
  input  rd_addr_t         addr,
  input  logic             wide,
  input  logic             wr_en,
  input  logic [RD_DW-1:0] wdata,
  output logic [RD_DW-1:0] rdata
);

  localparam int PROM_AW = $clog2(PROM_BYTES);
  localparam int PMEM_AW = $clog2(PMEM_BYTES);
  localparam logic [PMEM_AW-1:0] PMEM_OFS = PMEM_AW'(PMEM_BASE);

  rd_byte_t prom_mem [PROM_BYTES];
  rd_byte_t pkt_mem  [PMEM_BYTES];

  function automatic logic f_in_prom(input rd_addr_t a);
    return int'(a) < PROM_BYTES;
  endfunction

  function automatic logic f_in_pmem(input rd_addr_t a);
    return (int'(a) >= PMEM_BASE) && (int'(a) < PMEM_BASE + PMEM_BYTES);
  endfunction

  rd_addr_t base;
  logic [RD_LANES-1:0] lane_on;
  logic [RD_LANES-1:0] lane_prom;
  logic [RD_LANES-1:0] lane_pmem;
  logic [RD_LANES-1:0][PROM_AW-1:0] prom_idx;
  logic [RD_LANES-1:0][PMEM_AW-1:0] pmem_idx;
  logic [RD_LANES-1:0][RD_BW-1:0]   lane_rd;

  // word accesses use the even address below the pointer
  assign base = wide ? {addr[RD_AW-1:1], 1'b0} : addr;

  for (genvar g = 0; g < RD_LANES; g++) begin : g_lane
    rd_addr_t la;
    assign la          = base + rd_addr_t'(g);
    assign lane_on[g]  = (g == 0) || wide;
    assign lane_prom[g] = f_in_prom(la);
    assign lane_pmem[g] = f_in_pmem(la);
    assign prom_idx[g] = la[PROM_AW-1:0];
    assign pmem_idx[g] = la[PMEM_AW-1:0] - PMEM_OFS;
    assign lane_rd[g]  = !lane_on[g]  ? '0 :
                         lane_prom[g] ? prom_mem[prom_idx[g]] :
                         lane_pmem[g] ? pkt_mem[pmem_idx[g]] : '1;
  end

  assign rdata = lane_rd;

  always_ff @(posedge clk) begin
    for (int l = 0; l < RD_LANES; l++) begin
      if (wr_en && lane_on[l]) begin
        if (lane_prom[l])      prom_mem[prom_idx[l]] <= wdata[l*RD_BW +: RD_BW];
        else if (lane_pmem[l]) pkt_mem[pmem_idx[l]]  <= wdata[l*RD_BW +: RD_BW];
      end
    end
  end

endmodule

// File: rtl/rdma_irq.sv
module rdma_irq import rdma_pkg::*; (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BIT_POWERUP-1:0] set_vec,
  input  logic                   clr_wr,
  input  logic [BIT_POWERUP-1:0] clr_data,
  input  logic                   cmd_wr,
  input  logic                   mask_wr,
  input  rd_byte_t               mask_data,
  output rd_byte_t               flags,
  output rd_byte_t               mask,
  output logic                   irq
);

  for (genvar b = 0; b < RD_BW; b++) begin : g_flag
    if (b == BIT_POWERUP) begin : g_pwr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flags[b] <= 1'b1;
        else if (cmd_wr) flags[b] <= 1'b0;
      end
    end else begin : g_evt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags[b] <= 1'b0;
        else        flags[b] <= (flags[b] & ~(clr_wr & clr_data[b])) | set_vec[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (mask_wr) mask <= mask_data;
  end

  assign irq = |(flags & mask & IRQ_ELIGIBLE);

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_data[BIT_XFER_DONE] && !set_vec[BIT_XFER_DONE]) |=> !flags[BIT_XFER_DONE]); // R11
  AST_TOP_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_wr && flags[BIT_POWERUP]) |=> flags[BIT_POWERUP]); // R11
  AST_TOP_FLAG_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[BIT_POWERUP] |=> !flags[BIT_POWERUP]); // R11
  AST_DONE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[BIT_XFER_DONE] |=> flags[BIT_XFER_DONE]); // R6

endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine import rdma_pkg::*; #(
  parameter int PROM_BYTES = 32,
  parameter int PMEM_BASE  = 1024,
  parameter int PMEM_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        dp_rd,
  input  logic        dp_wr,
  input  logic [15:0] dp_wdata,
  output logic [15:0] dp_rdata,
  input  logic [5:0]  ev_set,
  output logic        irq
);

  rd_addr_t first_addr, end_addr, cur_addr;
  rd_cnt_t  cur_cnt;
  rd_byte_t flags, mask;
  logic wide, ld_ptr_l, ld_ptr_h, ld_len_l, ld_len_h;
  logic cmd_wr, xfer_req, flags_wr, mask_wr;
  logic cnt_zero, xfer_done, mem_wr, step, zero_len_hit;
  logic [BIT_POWERUP-1:0] set_vec;

  // internal events named for the checks below
  assign mem_wr       = dp_wr && !dp_rd && !cnt_zero;
  assign step         = dp_rd || mem_wr;
  assign zero_len_hit = cmd_wr && xfer_req && cnt_zero;
  assign set_vec      = {xfer_done | zero_len_hit, ev_set};

  rdma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .flags(flags), .mask(mask), .cur_addr(cur_addr), .cur_cnt(cur_cnt),
    .first_addr(first_addr), .end_addr(end_addr), .wide(wide),
    .ld_ptr_l(ld_ptr_l), .ld_ptr_h(ld_ptr_h), .ld_len_l(ld_len_l), .ld_len_h(ld_len_h),
    .cmd_wr(cmd_wr), .xfer_req(xfer_req), .flags_wr(flags_wr), .mask_wr(mask_wr),
    .reg_rdata(reg_rdata)
  );

  rdma_xfer u_xfer (
    .clk(clk), .rst_n(rst_n),
    .ld_ptr_l(ld_ptr_l), .ld_ptr_h(ld_ptr_h), .ld_len_l(ld_len_l), .ld_len_h(ld_len_h),
    .ld_data(reg_wdata), .step(step), .wide(wide),
    .first_addr(first_addr), .end_addr(end_addr),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .cnt_zero(cnt_zero), .xfer_done(xfer_done)
  );

  rdma_mem #(.PROM_BYTES(PROM_BYTES), .PMEM_BASE(PMEM_BASE), .PMEM_BYTES(PMEM_BYTES)) u_mem (
    .clk(clk), .addr(cur_addr), .wide(wide), .wr_en(mem_wr),
    .wdata(dp_wdata), .rdata(dp_rdata)
  );

  rdma_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_wr(flags_wr), .clr_data(reg_wdata[BIT_POWERUP-1:0]), .cmd_wr(cmd_wr),
    .mask_wr(mask_wr), .mask_data(reg_wdata),
    .flags(flags), .mask(mask), .irq(irq)
  );

  AST_IDLE_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_wr && !dp_rd && cnt_zero && !reg_wr) |=> $stable(cur_addr)); // R7
  AST_ZERO_LEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    zero_len_hit |=> flags[BIT_XFER_DONE]); // R9
  AST_CMD_DROPS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !flags[BIT_POWERUP]); // R11

endmodule

// File: tb/tb_rdma_port_engine.sv
module tb_rdma_port_engine;

  localparam logic [3:0] A_CMD = 4'h0, A_RLO = 4'h1, A_RHI = 4'h2, A_PL = 4'h3, A_PH = 4'h4;
  localparam logic [3:0] A_LL = 4'h5, A_LH = 4'h6, A_FLG = 4'h7, A_MSK = 4'h8, A_WID = 4'h9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic dp_rd = 1'b0;
  logic dp_wr = 1'b0;
  logic [15:0] dp_wdata = 16'h0;
  logic [15:0] dp_rdata;
  logic [5:0] ev_set = 6'h0;
  logic irq;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  rdma_port_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_wdata(dp_wdata),
    .dp_rdata(dp_rdata), .ev_set(ev_set), .irq(irq)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'hA5;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd_reg(a, v);
    chk(req, {8'h00, v}, {8'h00, exp});
  endtask

  task automatic set_ptr(input logic [15:0] a);
    wr_reg(A_PL, a[7:0]);
    wr_reg(A_PH, a[15:8]);
  endtask

  task automatic set_len(input logic [15:0] n);
    wr_reg(A_LL, n[7:0]);
    wr_reg(A_LH, n[15:8]);
  endtask

  task automatic chk_ptr(input string req, input logic [15:0] exp);
    chk_reg(req, A_PL, exp[7:0]);
    chk_reg(req, A_PH, exp[15:8]);
  endtask

  task automatic chk_len(input string req, input logic [15:0] exp);
    chk_reg(req, A_LL, exp[7:0]);
    chk_reg(req, A_LH, exp[15:8]);
  endtask

  task automatic chk_irq(input string req, input logic exp);
    @(negedge clk);
    #1 chk(req, {15'h0, irq}, {15'h0, exp});
  endtask

  // driver: a data-port read pushes the expected word for the monitor
  task automatic dp_read(input string req, input logic [15:0] exp);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    dp_rd = 1'b1;
    @(negedge clk);
    dp_rd = 1'b0;
  endtask

  task automatic dp_write(input logic [15:0] d);
    @(negedge clk);
    dp_wr = 1'b1; dp_wdata = d;
    @(negedge clk);
    dp_wr = 1'b0;
  endtask

  // monitor: compares the read word in the strobe cycle, before the edge moves the pointer
  always @(negedge clk) begin
    #1;
    if (dp_rd) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: actual=%h expected=none", dp_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (dp_rdata !== e) begin
          fails++;
          $display("FAIL %s: actual=%h expected=%h", t, dp_rdata, e);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_reg("R1", A_FLG, 8'h80);
    chk_reg("R1", A_MSK, 8'h00);
    chk_ptr("R1", 16'h0000);
    chk_len("R1", 16'h0000);
    chk_reg("R1", A_RLO, 8'h00);
    chk_reg("R1", A_RHI, 8'h00);
    chk_reg("R1", A_WID, 8'h00);
    chk_irq("R1", 1'b0);

    // R11 flag write leaves bit 7; R10 bit 7 never drives irq
    wr_reg(A_FLG, 8'h80);
    chk_reg("R11", A_FLG, 8'h80);
    wr_reg(A_MSK, 8'h80);
    chk_irq("R10", 1'b0);

    // R2 byte halves
    set_ptr(16'h1234);
    chk_ptr("R2", 16'h1234);
    wr_reg(A_PL, 8'h56);
    chk_ptr("R2", 16'h1256);
    set_len(16'hABCD);
    wr_reg(A_LH, 8'h0F);
    chk_len("R2", 16'h0FCD);

    // R9 zero-length command, R11 command clears bit 7
    set_len(16'h0000);
    wr_reg(A_CMD, 8'h02);
    chk_reg("R9", A_FLG, 8'h40);
    chk_irq("R10", 1'b0);
    wr_reg(A_MSK, 8'h40);
    chk_irq("R10", 1'b1);
    wr_reg(A_FLG, 8'hFF);
    chk_reg("R11", A_FLG, 8'h00);
    chk_irq("R10", 1'b0);

    // ring 0x0400..0x05FF
    wr_reg(A_RLO, 8'h04);
    wr_reg(A_RHI, 8'h06);

    // R3 / R13 byte writes
    set_ptr(16'h0400);
    set_len(16'd9);
    @(negedge clk);
    dp_wr = 1'b1; dp_wdata = {8'h00, pat(16'h0400)}; reg_addr = A_PL;
    #1 chk("R13", {8'h00, reg_rdata}, 16'h0000);
    @(negedge clk);
    dp_wr = 1'b0;
    #1 chk("R13", {8'h00, reg_rdata}, 16'h0001);
    chk_len("R3", 16'd8);
    for (int a = 16'h0401; a <= 16'h0408; a++) dp_write({8'h00, pat(a)});
    chk_ptr("R3", 16'h0409);
    chk_len("R6", 16'h0000);
    chk_reg("R6", A_FLG, 8'h40);
    wr_reg(A_FLG, 8'h7F);

    // R7 write with zero length is inert
    set_ptr(16'h0408);
    dp_write(16'h00EE);
    chk_ptr("R7", 16'h0408);
    chk_len("R7", 16'h0000);
    chk_reg("R7", A_FLG, 8'h00);
    set_len(16'd1);
    dp_read("R7", {8'h00, pat(16'h0408)});

    // R3 byte read-back
    set_ptr(16'h0400);
    set_len(16'd9);
    for (int a = 16'h0400; a <= 16'h0408; a++) dp_read("R3", {8'h00, pat(a)});
    chk_ptr("R3", 16'h0409);

    // R4 word reads from an odd pointer
    wr_reg(A_WID, 8'h01);
    wr_reg(A_FLG, 8'h7F);
    set_ptr(16'h0401);
    set_len(16'd3);
    dp_read("R4", {pat(16'h0401), pat(16'h0400)});
    chk_ptr("R4", 16'h0403);
    chk_len("R6", 16'd1);
    chk_reg("R6", A_FLG, 8'h00);
    dp_read("R4", {pat(16'h0403), pat(16'h0402)});
    chk_ptr("R4", 16'h0405);
    chk_len("R6", 16'h0000);
    chk_reg("R6", A_FLG, 8'h40);
    wr_reg(A_FLG, 8'h7F);
    // R6 read with zero length still proceeds and flags completion
    dp_read("R6", {pat(16'h0405), pat(16'h0404)});
    chk_ptr("R6", 16'h0407);
    chk_reg("R6", A_FLG, 8'h40);
    wr_reg(A_FLG, 8'h7F);

    // R4 word write, byte read-back for lane order
    set_ptr(16'h0410);
    set_len(16'd4);
    dp_write(16'hBEEF);
    dp_write(16'h1234);
    wr_reg(A_WID, 8'h00);
    set_ptr(16'h0410);
    set_len(16'd4);
    dp_read("R4", 16'h00EF);
    dp_read("R4", 16'h00BE);
    dp_read("R4", 16'h0034);
    dp_read("R4", 16'h0012);

    // R5 wrap in word mode
    wr_reg(A_WID, 8'h01);
    set_ptr(16'h05FE);
    set_len(16'd4);
    dp_write(16'hCAFE);
    chk_ptr("R5", 16'h0400);
    dp_write(16'h0B0B);
    chk_ptr("R5", 16'h0402);
    // R5 wrap in byte mode
    wr_reg(A_WID, 8'h00);
    set_ptr(16'h05FE);
    set_len(16'd3);
    dp_read("R5", 16'h00FE);
    dp_read("R5", 16'h00CA);
    chk_ptr("R5", 16'h0400);
    dp_read("R5", 16'h000B);

    // R8 windows
    set_ptr(16'h001F);
    set_len(16'd1);
    dp_write(16'h0077);
    set_ptr(16'h001F);
    set_len(16'd1);
    dp_read("R8", 16'h0077);
    set_ptr(16'h0020);
    set_len(16'd1);
    dp_write(16'h0099);
    set_ptr(16'h0020);
    set_len(16'd1);
    dp_read("R8", 16'h00FF);
    set_ptr(16'h03FF);
    set_len(16'd1);
    dp_read("R8", 16'h00FF);
    wr_reg(A_WID, 8'h01);
    set_ptr(16'h0800);
    set_len(16'd2);
    dp_read("R8", 16'hFFFF);
    wr_reg(A_WID, 8'h00);

    // R12 events, R10 masking, R11 selective clear
    wr_reg(A_FLG, 8'h7F);
    wr_reg(A_MSK, 8'h00);
    @(negedge clk);
    ev_set = 6'b000101;
    @(negedge clk);
    ev_set = 6'b000000;
    chk_reg("R12", A_FLG, 8'h05);
    chk_irq("R10", 1'b0);
    wr_reg(A_MSK, 8'h04);
    chk_irq("R10", 1'b1);
    wr_reg(A_FLG, 8'h04);
    chk_reg("R11", A_FLG, 8'h01);
    chk_irq("R10", 1'b0);
    wr_reg(A_MSK, 8'h01);
    chk_irq("R10", 1'b1);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      tests++;
      fails++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule